// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit Slip

This block gathers serial data into 8-bit parallel words. It takes the data from one of two serial lanes, and a lane select input picks which one. The second lane gives a loop-back test path. A rate select sets how many bits are taken per clock:
- **Single-rate mode** takes one bit per clock.
- **Double-rate mode** takes two bits per clock. Both bits arrive together on a 2-bit lane input, with the earlier bit in bit 0.

The first bit of a word lands in the lowest output bit. A one-clock strobe marks each new word.

Word framing is aligned with a slip request. This input may change at any time relative to the clock, so it first passes through a two-flop synchronizer. It is then qualified: it must be seen high on two consecutive clocks. Each qualified request discards exactly one serial bit, which moves the word boundary one bit later. A clock enable freezes all internal state. An asynchronous active-low reset clears the bit count, the partial word and the outputs.

Top module: `deser_bitslip`

## Requirements
- R1: While `rst_n` is low, `par_q` is 0 and `word_stb` is 0, without waiting for a clock edge, and the partial word and bit count restart from empty.
- R2: The first serial bit of a word appears on `par_q[0]`, the next on `par_q[1]`, and so on up to `par_q[7]`.
- R3: `lane_sel` = 0 takes data from `ser_a`; `lane_sel` = 1 takes data from `ser_b`. The lane that is not selected has no effect on the outputs.
- R4: With `rate_sel` = 1 (single rate), one bit is taken per enabled clock from bit 0 of the selected lane, and lane bit 1 is ignored. Without slips, a word is strobed every 8 enabled clocks.
- R5: With `rate_sel` = 0 (double rate), two bits are taken per enabled clock, lane bit 0 first and then lane bit 1. Without slips, a word is strobed every 4 enabled clocks. A word may complete between the two bits of one clock, and the bit that is left over starts the next word.
- R6: `par_q` changes only in the cycle where `word_stb` is high. `word_stb` is never high on two consecutive cycles.
- R7: If `slip_req` is sampled high on two consecutive enabled clock edges, exactly one serial bit is discarded. The discarded bit is the one that would have been taken at the second enabled edge after those two.
- R8: `slip_req` held high continuously causes only one slip. A high of only one enabled clock causes none. Each further slip needs `slip_req` to go low and then be high again for two clocks.
- R9: A slip in double-rate mode discards lane bit 0 (the earlier bit) and keeps lane bit 1.
- R10: While `clk_en` is low, no bit is taken, the count, partial word, slip history and `par_q` hold their values, and `word_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Synchronous enable for all internal state |
| rate_sel | input | 1 | 1 = one bit per clock, 0 = two bits per clock |
| lane_sel | input | 1 | 0 = lane A, 1 = lane B |
| ser_a | input | 2 | Serial lane A; bit 0 is the earlier bit |
| ser_b | input | 2 | Serial lane B; bit 0 is the earlier bit |
| slip_req | input | 1 | Asynchronous request to discard one bit |
| par_q | output | 8 | Parallel word, first bit in bit 0 |
| word_stb | output | 1 | One-clock pulse when `par_q` is loaded |

## Verification
The bench builds the block with the default values: an 8-bit word and a two-stage synchronizer. With an 8-bit word, double-rate mode can complete a word between the two bits of one clock once an odd number of slips has moved the framing, so the bench can reach that split case. The two-stage synchronizer sets the slip latency to three enabled edges. That latency is short enough that one-clock pulses, two-clock pulses, held requests and pulses during clock-enable gaps can all be placed at exact cycles relative to the word boundary.

// File: rtl/deser_pkg.sv
package deser_pkg;
    localparam int LANE_W = 2;

    typedef enum logic {
        RATE_DOUBLE = 1'b0,
        RATE_SINGLE = 1'b1
    } rate_e;
endpackage

// File: rtl/deser_slip_qual.sv
module deser_slip_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic req_i,
    output logic slip_o
);
    localparam int CHAIN_W = SYNC_STAGES + 2;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.chain = {st_q.chain[CHAIN_W-2:0], req_i};
        end
    end

    // synchronized level seen on two consecutive clocks, first time only
    assign slip_o = en_i
                  & st_q.chain[SYNC_STAGES-1]
                  & st_q.chain[SYNC_STAGES]
                  & ~st_q.chain[SYNC_STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/deser_lane_pick.sv
module deser_lane_pick
    import deser_pkg::*;
(
    input  logic              lane_sel_i,
    input  logic [LANE_W-1:0] lane_a_i,
    input  logic [LANE_W-1:0] lane_b_i,
    output logic [LANE_W-1:0] bits_o
);
    always_comb begin
        bits_o = lane_sel_i ? lane_b_i : lane_a_i;
    end
endmodule

// File: rtl/deser_pack.sv
module deser_pack
    import deser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  rate_e             rate_i,
    input  logic              slip_i,
    input  logic [LANE_W-1:0] bits_i,
    output logic [WORD_W-1:0] par_o,
    output logic              stb_o
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] par;
        logic              stb;
    } state_t;

    state_t            st_d, st_q;
    logic [1:0]        take_n;
    logic [LANE_W-1:0] seq;

    // how many bits enter this cycle and in which order
    always_comb begin
        take_n = 2'd0;
        seq    = '0;
        if (rate_i == RATE_DOUBLE) begin
            if (slip_i) begin
                take_n = 2'd1;
                seq[0] = bits_i[1];
            end else begin
                take_n = 2'd2;
                seq    = bits_i;
            end
        end else begin
            take_n = slip_i ? 2'd0 : 2'd1;
            seq[0] = bits_i[0];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (en_i) begin
            for (int i = 0; i < LANE_W; i++) begin
                if (i < int'(take_n)) begin
                    st_d.acc[st_d.cnt] = seq[i];
                    if (st_d.cnt == LAST_POS) begin
                        st_d.par = st_d.acc;
                        st_d.stb = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_d.cnt + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_o = st_q.par;
    assign stb_o = st_q.stb;
endmodule

// File: rtl/deser_bitslip.sv
module deser_bitslip
    import deser_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              rate_sel,
    input  logic              lane_sel,
    input  logic [LANE_W-1:0] ser_a,
    input  logic [LANE_W-1:0] ser_b,
    input  logic              slip_req,
    output logic [WORD_W-1:0] par_q,
    output logic              word_stb
);
    logic              slip_now;
    logic [LANE_W-1:0] lane_bits;
    rate_e             rate;

    assign rate = rate_e'(rate_sel);

    deser_slip_qual #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_slip (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clk_en),
        .req_i  (slip_req),
        .slip_o (slip_now)
    );

    deser_lane_pick u_pick (
        .lane_sel_i (lane_sel),
        .lane_a_i   (ser_a),
        .lane_b_i   (ser_b),
        .bits_o     (lane_bits)
    );

    deser_pack #(
        .WORD_W (WORD_W)
    ) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clk_en),
        .rate_i (rate),
        .slip_i (slip_now),
        .bits_i (lane_bits),
        .par_o  (par_q),
        .stb_o  (word_stb)
    );
endmodule

// File: rtl/deser_bitslip_chk.sv
module deser_bitslip_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic [WORD_W-1:0] par_q,
    input logic              word_stb
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (par_q == '0 && !word_stb));

    // R6
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |-> $stable(par_q));

    // R6
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    // R10
    frozen_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !word_stb);

    // R10
    frozen_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(par_q));
endmodule

bind deser_bitslip deser_bitslip_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .par_q    (par_q),
    .word_stb (word_stb)
);

// File: tb/test_deser_bitslip.sv
module test_deser_bitslip;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       clk_en = 1'b0;
    logic       rate_sel = 1'b1;
    logic       lane_sel = 1'b0;
    logic [1:0] ser_a = '0;
    logic [1:0] ser_b = '0;
    logic       slip_req = 1'b0;
    logic [7:0] par_q;
    logic       word_stb;

    int checks = 0;
    int failures = 0;
    int stb_seen = 0;

    bit         bq[$];
    bit         hist[$];
    logic [7:0] exp_par = '0;
    logic       exp_stb = 1'b0;

    always #10 clk = ~clk;

    deser_bitslip i_deser_bitslip (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .rate_sel (rate_sel),
        .lane_sel (lane_sel),
        .ser_a    (ser_a),
        .ser_b    (ser_b),
        .slip_req (slip_req),
        .par_q    (par_q),
        .word_stb (word_stb)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        bq.delete();
        hist = '{0, 0, 0, 0};
        exp_par = '0;
        exp_stb = 1'b0;
    endtask

    task automatic push_bit(input bit b);
        bq.push_back(b);
        if (bq.size() == 8) begin
            for (int k = 0; k < 8; k++) exp_par[k] = bq[k];
            exp_stb = 1'b1;
            bq.delete();
        end
    endtask

    // inputs already driven (after negedge); predict next edge, then compare
    task automatic step(input string req);
        logic [1:0] ln;
        bit slip;
        exp_stb = 1'b0;
        if (clk_en) begin
            slip = hist[1] && hist[2] && !hist[3];
            hist.push_front(slip_req);
            void'(hist.pop_back());
            ln = lane_sel ? ser_b : ser_a;
            if (rate_sel) begin
                if (!slip) push_bit(ln[0]);
            end else begin
                if (!slip) push_bit(ln[0]);
                push_bit(ln[1]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (word_stb) stb_seen++;
        check(req, {word_stb, par_q}, {exp_stb, exp_par});
    endtask

    task automatic rnd_lanes();
        ser_a = 2'($urandom);
        ser_b = 2'($urandom);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        #1 rst_n = 1'b0;
        #2;
        // R1 outputs clear during reset
        check("R1", {word_stb, par_q}, 9'h000);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clk_en = 1'b1;

        // R2 R4 single rate, lane A, known pattern then random
        rate_sel = 1'b1; lane_sel = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ser_a = {1'b1, 1'(i == 0 || i == 2)};
            ser_b = 2'b11;
            step("R2");
        end
        check("R2", {1'b0, par_q}, {1'b0, 8'h05});
        stb_seen = 0;
        for (int i = 0; i < 80; i++) begin rnd_lanes(); step("R4"); end
        check("R4", 9'(stb_seen), 9'd10);

        // R3 lane B
        lane_sel = 1'b1;
        for (int i = 0; i < 40; i++) begin rnd_lanes(); step("R3"); end

        // R5 double rate
        rate_sel = 1'b0;
        stb_seen = 0;
        for (int i = 0; i < 40; i++) begin rnd_lanes(); step("R5"); end
        check("R5", 9'(stb_seen), 9'd10);

        // R7 slip in single rate: two-clock pulses, several times
        rate_sel = 1'b1; lane_sel = 1'b0;
        for (int p = 0; p < 3; p++) begin
            slip_req = 1'b1;
            for (int i = 0; i < 2; i++) begin rnd_lanes(); step("R7"); end
            slip_req = 1'b0;
            for (int i = 0; i < 11; i++) begin rnd_lanes(); step("R7"); end
        end

        // R8 one-clock pulse: no slip
        slip_req = 1'b1; rnd_lanes(); step("R8");
        slip_req = 1'b0;
        for (int i = 0; i < 12; i++) begin rnd_lanes(); step("R8"); end
        // R8 held high: one slip only
        slip_req = 1'b1;
        for (int i = 0; i < 30; i++) begin rnd_lanes(); step("R8"); end
        slip_req = 1'b0;
        for (int i = 0; i < 8; i++) begin rnd_lanes(); step("R8"); end

        // R9 R5 double-rate slips, odd count gives split words
        rate_sel = 1'b0; lane_sel = 1'b1;
        for (int p = 0; p < 3; p++) begin
            slip_req = 1'b1;
            for (int i = 0; i < 2; i++) begin rnd_lanes(); step("R9"); end
            slip_req = 1'b0;
            for (int i = 0; i < 9; i++) begin rnd_lanes(); step("R9"); end
        end

        // R10 clock enable gaps, including a slip request across a gap
        for (int i = 0; i < 60; i++) begin
            clk_en = (i % 3) != 1;
            slip_req = (i >= 20 && i < 26);
            rnd_lanes();
            step("R10");
        end
        clk_en = 1'b0;
        stb_seen = 0;
        for (int i = 0; i < 12; i++) begin rnd_lanes(); step("R10"); end
        check("R10", 9'(stb_seen), 9'd0);
        clk_en = 1'b1; slip_req = 1'b0;
        rate_sel = 1'b1;
        for (int i = 0; i < 20; i++) begin rnd_lanes(); step("R10"); end

        // R1 reset mid-word, asynchronous
        for (int i = 0; i < 3; i++) begin rnd_lanes(); step("R1"); end
        #3 rst_n = 1'b0;
        #1 check("R1", {word_stb, par_q}, 9'h000);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 24; i++) begin rnd_lanes(); step("R1"); end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule